// File: doc/BRIEF.md
# Relative Register Specifier Translator

This block sits in the operand-fetch stage of a multithreaded processor that keeps many task frames loaded at once. An instruction names its registers relative to a frame: the issuing frame itself, its child, its parent or a fixed global frame. Inside a trap handler it may instead name the faulting instruction's saved operands. The translator turns each such specifier into an absolute (frame, register) pair. It drives two read ports of an external register file with those pairs in the same cycle, and reports the absolute destination.

The tagged words that come back are then shaped. A field selector can pass the word unchanged, or it can move the data, generation or type field into the data position, with a small-integer type tag and a zero generation filled in. The second operand can be replaced by an immediate. Register 0 of any frame reads as a zero small integer. A specifier that goes through a missing parent or child link is flagged. All results are registered and appear one cycle after the request.

Top module: `regspec_xlate`

## Requirements
- R1: Selector code 0 resolves to the issuing frame (`cur_frame`), code 1 to the child link (`chd_frame`) and code 2 to the parent link (`par_frame`). The specifier's register number passes through unchanged.
- R2: Selector code 3 resolves to the fixed frame `GLOBAL_FRAME` (default 7), keeping the specifier's register number.
- R3: Selector codes 4, 5 and 6 resolve to the saved absolute specifiers `trap_src1`, `trap_src2` and `trap_dst`. Each is packed {frame, register}, and the specifier's own register number is ignored.
- R4: Bit 0 of `spec_bad` flags operand A, bit 1 operand B and bit 2 the destination. A bit is set when its specifier uses code 1 while `chd_ok` is low, code 2 while `par_ok` is low, or the reserved code 7. Code 7 resolves like code 0. A null link still drives the link's frame number. Bit 1 is forced low while `imm_en` is high.
- R5: Field code 0 gives the whole word unchanged. Words are packed {gen[GW], type[TW], data[DW]} from MSB to LSB.
- R6: Field code 1 (data), 2 (generation) or 3 (type) places that field, zero-extended, in the data position, with type `FIXNUM_CODE` (default 1) and generation 0.
- R7: With `imm_en` high, operand B is {0, `FIXNUM_CODE`, `imm`}, whatever its specifier and field code.
- R8: A source that resolves to register 0 reads as {0, `FIXNUM_CODE`, 0} before field selection, whatever the file returns.
- R9: The destination is resolved with the same selector codes and no field selection, and is reported on `dst_frame`/`dst_reg`.
- R10: A request with `req_valid` high is captured at the following rising edge. `out_valid` is high for the next cycle. With `req_valid` low, `out_valid` drops and the operand, destination and flag outputs hold their values.
- R11: While `rst_n` is low, every registered output is zero.
- R12: `rf_a_*` and `rf_b_*` carry the resolved source addresses combinationally in the request cycle. The file returns `rf_a_word`/`rf_b_word` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| cur_frame | input | FW | Issuing frame number |
| par_frame | input | FW | Parent link |
| par_ok | input | 1 | Parent link is non-null |
| chd_frame | input | FW | Child link |
| chd_ok | input | 1 | Child link is non-null |
| trap_src1 | input | FW+RW | Saved first source {frame, reg} |
| trap_src2 | input | FW+RW | Saved second source {frame, reg} |
| trap_dst | input | FW+RW | Saved destination {frame, reg} |
| spec_a_base | input | 3 | Operand A selector code |
| spec_a_reg | input | RW | Operand A register number |
| spec_a_fld | input | 2 | Operand A field code |
| spec_b_base | input | 3 | Operand B selector code |
| spec_b_reg | input | RW | Operand B register number |
| spec_b_fld | input | 2 | Operand B field code |
| spec_d_base | input | 3 | Destination selector code |
| spec_d_reg | input | RW | Destination register number |
| imm_en | input | 1 | Replace operand B with the immediate |
| imm | input | DW | Immediate value |
| rf_a_frame | output | FW | Read port A frame |
| rf_a_reg | output | RW | Read port A register |
| rf_a_word | input | DW+TW+GW | Read port A data |
| rf_b_frame | output | FW | Read port B frame |
| rf_b_reg | output | RW | Read port B register |
| rf_b_word | input | DW+TW+GW | Read port B data |
| out_valid | output | 1 | Results below belong to last cycle's request |
| opnd_a | output | DW+TW+GW | Shaped operand A |
| opnd_b | output | DW+TW+GW | Shaped operand B |
| dst_frame | output | FW | Absolute destination frame |
| dst_reg | output | RW | Absolute destination register |
| spec_bad | output | 3 | Invalid-specifier flags {D, B, A} |

## Verification
The bench builds the block with FW=4, RW=3, DW=16, TW=4, GW=2, FIXNUM_CODE=2 and GLOBAL_FRAME=7. With words this small, each field of the modelled file contents is visibly distinct. The model stores its frame and register number in the data field and differing patterns in type and generation, so a wrong frame, a wrong field choice or a missed zero substitution for register 0 all show up as a different value. The trap-saved specifiers use frames 10 to 12, which no link uses, so an override that falls back to a link is caught.

// File: rtl/regspec_pkg.sv
package regspec_pkg;

  // Frame selector codes; the numeric values are part of the interface.
  typedef enum logic [2:0] {
    SEL_SELF     = 3'd0,
    SEL_CHILD    = 3'd1,
    SEL_PARENT   = 3'd2,
    SEL_GLOBAL   = 3'd3,
    SEL_TRAP_S1  = 3'd4,
    SEL_TRAP_S2  = 3'd5,
    SEL_TRAP_DST = 3'd6,
    SEL_RSVD     = 3'd7
  } frame_sel_e;

  // Field selector codes.
  typedef enum logic [1:0] {
    PICK_WORD = 2'd0,
    PICK_DATA = 2'd1,
    PICK_GEN  = 2'd2,
    PICK_TYPE = 2'd3
  } field_pick_e;

endpackage

// File: rtl/regspec_resolve.sv
module regspec_resolve
  import regspec_pkg::*;
#(
  parameter int FW           = 4,
  parameter int RW           = 4,
  parameter int GLOBAL_FRAME = 7
) (
  input  frame_sel_e        sel,
  input  logic [RW-1:0]     reg_in,
  input  logic [FW-1:0]     self_frame,
  input  logic [FW-1:0]     par_frame,
  input  logic              par_ok,
  input  logic [FW-1:0]     chd_frame,
  input  logic              chd_ok,
  input  logic [FW+RW-1:0]  trap_s1,
  input  logic [FW+RW-1:0]  trap_s2,
  input  logic [FW+RW-1:0]  trap_dst,
  output logic [FW-1:0]     abs_frame,
  output logic [RW-1:0]     abs_reg,
  output logic              bad
);

  // Returns {bad, frame, reg} for one relative specifier.
  function automatic logic [FW+RW:0] resolve_fn(
    input frame_sel_e       s,
    input logic [RW-1:0]    r_in,
    input logic [FW-1:0]    self_f,
    input logic [FW-1:0]    par_f,
    input logic             par_v,
    input logic [FW-1:0]    chd_f,
    input logic             chd_v,
    input logic [FW+RW-1:0] t1,
    input logic [FW+RW-1:0] t2,
    input logic [FW+RW-1:0] td
  );
    logic [FW-1:0] f;
    logic [RW-1:0] r;
    logic          b;
    f = self_f;
    r = r_in;
    b = 1'b0;
    case (s)
      SEL_SELF:     f = self_f;
      SEL_CHILD:    begin f = chd_f; b = !chd_v; end
      SEL_PARENT:   begin f = par_f; b = !par_v; end
      SEL_GLOBAL:   f = FW'(GLOBAL_FRAME);
      SEL_TRAP_S1:  {f, r} = t1;
      SEL_TRAP_S2:  {f, r} = t2;
      SEL_TRAP_DST: {f, r} = td;
      default:      b = 1'b1;
    endcase
    return {b, f, r};
  endfunction

  always_comb begin
    {bad, abs_frame, abs_reg} = resolve_fn(sel, reg_in, self_frame, par_frame,
                                           par_ok, chd_frame, chd_ok,
                                           trap_s1, trap_s2, trap_dst);
  end

endmodule

// File: rtl/regspec_field.sv
module regspec_field
  import regspec_pkg::*;
#(
  parameter int DW          = 32,
  parameter int TW          = 5,
  parameter int GW          = 3,
  parameter int RW          = 4,
  parameter int FIXNUM_CODE = 1
) (
  input  logic [DW+TW+GW-1:0] raw,
  input  logic [RW-1:0]       abs_reg,
  input  field_pick_e         pick,
  input  logic                imm_en,
  input  logic [DW-1:0]       imm,
  output logic [DW+TW+GW-1:0] shaped
);

  localparam int WW = DW + TW + GW;

  // A small-integer word carrying the given data.
  function automatic logic [WW-1:0] fixnum_word(input logic [DW-1:0] d);
    return {{GW{1'b0}}, TW'(FIXNUM_CODE), d};
  endfunction

  function automatic logic [WW-1:0] shape_fn(input logic [WW-1:0] w,
                                             input field_pick_e p);
    logic [GW-1:0] g;
    logic [TW-1:0] t;
    logic [DW-1:0] d;
    {g, t, d} = w;
    case (p)
      PICK_DATA: return fixnum_word(d);
      PICK_GEN:  return fixnum_word(DW'(g));
      PICK_TYPE: return fixnum_word(DW'(t));
      default:   return w;
    endcase
  endfunction

  logic [WW-1:0] src_word;
  logic          reg_is_zero;

  assign reg_is_zero = (abs_reg == '0);

  always_comb begin
    src_word = reg_is_zero ? fixnum_word('0) : raw;
    if (imm_en) shaped = fixnum_word(imm);
    else        shaped = shape_fn(src_word, pick);
  end

endmodule

// File: rtl/regspec_xlate.sv
module regspec_xlate
  import regspec_pkg::*;
#(
  parameter int FW           = 4,
  parameter int RW           = 4,
  parameter int DW           = 32,
  parameter int TW           = 5,
  parameter int GW           = 3,
  parameter int FIXNUM_CODE  = 1,
  parameter int GLOBAL_FRAME = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [FW-1:0]       cur_frame,
  input  logic [FW-1:0]       par_frame,
  input  logic                par_ok,
  input  logic [FW-1:0]       chd_frame,
  input  logic                chd_ok,
  input  logic [FW+RW-1:0]    trap_src1,
  input  logic [FW+RW-1:0]    trap_src2,
  input  logic [FW+RW-1:0]    trap_dst,
  input  logic [2:0]          spec_a_base,
  input  logic [RW-1:0]       spec_a_reg,
  input  logic [1:0]          spec_a_fld,
  input  logic [2:0]          spec_b_base,
  input  logic [RW-1:0]       spec_b_reg,
  input  logic [1:0]          spec_b_fld,
  input  logic [2:0]          spec_d_base,
  input  logic [RW-1:0]       spec_d_reg,
  input  logic                imm_en,
  input  logic [DW-1:0]       imm,
  output logic [FW-1:0]       rf_a_frame,
  output logic [RW-1:0]       rf_a_reg,
  input  logic [DW+TW+GW-1:0] rf_a_word,
  output logic [FW-1:0]       rf_b_frame,
  output logic [RW-1:0]       rf_b_reg,
  input  logic [DW+TW+GW-1:0] rf_b_word,
  output logic                out_valid,
  output logic [DW+TW+GW-1:0] opnd_a,
  output logic [DW+TW+GW-1:0] opnd_b,
  output logic [FW-1:0]       dst_frame,
  output logic [RW-1:0]       dst_reg,
  output logic [2:0]          spec_bad
);

  localparam int WW    = DW + TW + GW;
  localparam int NSPEC = 3;  // A, B, destination
  localparam int NSRC  = 2;  // A, B

  frame_sel_e    sel_v   [NSPEC];
  logic [RW-1:0] reg_v   [NSPEC];
  logic [FW-1:0] res_frame [NSPEC];
  logic [RW-1:0] res_reg   [NSPEC];
  logic [NSPEC-1:0] res_bad;

  logic [WW-1:0] raw_v    [NSRC];
  field_pick_e   pick_v   [NSRC];
  logic          imm_v    [NSRC];
  logic [WW-1:0] shaped_v [NSRC];

  // Named event wire: flags as they will be captured this cycle.
  logic [NSPEC-1:0] bad_now;

  always_comb begin
    sel_v[0] = frame_sel_e'(spec_a_base);
    sel_v[1] = frame_sel_e'(spec_b_base);
    sel_v[2] = frame_sel_e'(spec_d_base);
    reg_v[0] = spec_a_reg;
    reg_v[1] = spec_b_reg;
    reg_v[2] = spec_d_reg;
    raw_v[0] = rf_a_word;
    raw_v[1] = rf_b_word;
    pick_v[0] = field_pick_e'(spec_a_fld);
    pick_v[1] = field_pick_e'(spec_b_fld);
    imm_v[0]  = 1'b0;
    imm_v[1]  = imm_en;
  end

  for (genvar i = 0; i < NSPEC; i++) begin : g_res
    regspec_resolve #(
      .FW(FW), .RW(RW), .GLOBAL_FRAME(GLOBAL_FRAME)
    ) u_res (
      .sel        (sel_v[i]),
      .reg_in     (reg_v[i]),
      .self_frame (cur_frame),
      .par_frame  (par_frame),
      .par_ok     (par_ok),
      .chd_frame  (chd_frame),
      .chd_ok     (chd_ok),
      .trap_s1    (trap_src1),
      .trap_s2    (trap_src2),
      .trap_dst   (trap_dst),
      .abs_frame  (res_frame[i]),
      .abs_reg    (res_reg[i]),
      .bad        (res_bad[i])
    );
  end

  for (genvar j = 0; j < NSRC; j++) begin : g_fld
    regspec_field #(
      .DW(DW), .TW(TW), .GW(GW), .RW(RW), .FIXNUM_CODE(FIXNUM_CODE)
    ) u_fld (
      .raw     (raw_v[j]),
      .abs_reg (res_reg[j]),
      .pick    (pick_v[j]),
      .imm_en  (imm_v[j]),
      .imm     (imm),
      .shaped  (shaped_v[j])
    );
  end

  assign rf_a_frame = res_frame[0];
  assign rf_a_reg   = res_reg[0];
  assign rf_b_frame = res_frame[1];
  assign rf_b_reg   = res_reg[1];

  assign bad_now = {res_bad[2], res_bad[1] & ~imm_en, res_bad[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      opnd_a    <= '0;
      opnd_b    <= '0;
      dst_frame <= '0;
      dst_reg   <= '0;
      spec_bad  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        opnd_a    <= shaped_v[0];
        opnd_b    <= shaped_v[1];
        dst_frame <= res_frame[2];
        dst_reg   <= res_reg[2];
        spec_bad  <= bad_now;
      end
    end
  end

endmodule

// File: rtl/regspec_xlate_chk.sv
module regspec_xlate_chk #(
  parameter int FW           = 4,
  parameter int RW           = 4,
  parameter int DW           = 32,
  parameter int TW           = 5,
  parameter int GW           = 3,
  parameter int FIXNUM_CODE  = 1,
  parameter int GLOBAL_FRAME = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [FW-1:0]       cur_frame,
  input logic [2:0]          spec_a_base,
  input logic [1:0]          spec_a_fld,
  input logic [2:0]          spec_d_base,
  input logic                imm_en,
  input logic [DW-1:0]       imm,
  input logic [FW-1:0]       rf_a_frame,
  input logic [RW-1:0]       rf_a_reg,
  input logic                out_valid,
  input logic [DW+TW+GW-1:0] opnd_a,
  input logic [DW+TW+GW-1:0] opnd_b,
  input logic [FW-1:0]       dst_frame,
  input logic [2:0]          spec_bad,
  input logic [2:0]          bad_now
);

  a_r1_self_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && spec_a_base == 3'd0 |-> rf_a_frame == cur_frame);

  a_r2_global_dst: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && spec_d_base == 3'd3 |=> dst_frame == FW'(GLOBAL_FRAME));

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bad_now[0] |=> spec_bad[0]);

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bad_now[1] |=> !spec_bad[1]);

  a_r7_imm_word: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && imm_en |=>
      opnd_b == {{GW{1'b0}}, TW'(FIXNUM_CODE), $past(imm)});

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rf_a_reg == '0 && spec_a_fld == 2'd0 |=>
      opnd_a == {{GW{1'b0}}, TW'(FIXNUM_CODE), {DW{1'b0}}});

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r10_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(opnd_a) && $stable(opnd_b) && $stable(spec_bad));

endmodule

bind regspec_xlate regspec_xlate_chk #(
  .FW(FW), .RW(RW), .DW(DW), .TW(TW), .GW(GW),
  .FIXNUM_CODE(FIXNUM_CODE), .GLOBAL_FRAME(GLOBAL_FRAME)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_frame(cur_frame),
  .spec_a_base(spec_a_base), .spec_a_fld(spec_a_fld),
  .spec_d_base(spec_d_base), .imm_en(imm_en), .imm(imm),
  .rf_a_frame(rf_a_frame), .rf_a_reg(rf_a_reg), .out_valid(out_valid),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_frame(dst_frame),
  .spec_bad(spec_bad), .bad_now(bad_now)
);

// File: tb/regspec_xlate_tb.sv
module regspec_xlate_tb_top;

  localparam int FW = 4, RW = 3, DW = 16, TW = 4, GW = 2;
  localparam int WW = DW + TW + GW;
  localparam logic [TW-1:0] FIX = 4'd2;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n, req_valid, par_ok, chd_ok, imm_en;
  logic [FW-1:0] cur_frame, par_frame, chd_frame;
  logic [FW+RW-1:0] trap_src1, trap_src2, trap_dst;
  logic [2:0] spec_a_base, spec_b_base, spec_d_base;
  logic [RW-1:0] spec_a_reg, spec_b_reg, spec_d_reg;
  logic [1:0] spec_a_fld, spec_b_fld;
  logic [DW-1:0] imm;
  logic [FW-1:0] rf_a_frame, rf_b_frame, dst_frame;
  logic [RW-1:0] rf_a_reg, rf_b_reg, dst_reg;
  logic [WW-1:0] rf_a_word, rf_b_word, opnd_a, opnd_b;
  logic out_valid;
  logic [2:0] spec_bad;

  int checks = 0;
  int failures = 0;

  // Register file model: every field reflects the address differently.
  function automatic logic [WW-1:0] rf_model(input logic [FW-1:0] f,
                                             input logic [RW-1:0] r);
    return {r[1:0], f ^ {1'b0, r}, f, 1'b1, r, 8'h5A};
  endfunction

  assign rf_a_word = rf_model(rf_a_frame, rf_a_reg);
  assign rf_b_word = rf_model(rf_b_frame, rf_b_reg);

  regspec_xlate #(
    .FW(FW), .RW(RW), .DW(DW), .TW(TW), .GW(GW),
    .FIXNUM_CODE(2), .GLOBAL_FRAME(7)
  ) dut_i (.*);

  typedef struct packed {
    logic [2:0] ab; logic [2:0] ar; logic [1:0] af;
    logic [2:0] bb; logic [2:0] br; logic [1:0] bf;
    logic [2:0] db; logic [2:0] dr;
    logic ie; logic pok; logic cok;
    logic [2:0] xbad; logic [3:0] xdf;
  } vec_t;

  // ab ar af | bb br bf | db dr | ie pok cok | bad dframe
  localparam vec_t VECS [9] = '{
    '{3'd0,3'd1,2'd0, 3'd0,3'd2,2'd0, 3'd0,3'd3, 1'b0,1'b1,1'b1, 3'b000,4'd3},  // R1 R5
    '{3'd1,3'd4,2'd1, 3'd2,3'd5,2'd2, 3'd1,3'd6, 1'b0,1'b1,1'b1, 3'b000,4'd9},  // R1 R6
    '{3'd2,3'd7,2'd3, 3'd3,3'd1,2'd0, 3'd3,3'd2, 1'b0,1'b1,1'b1, 3'b000,4'd7},  // R2 R6
    '{3'd4,3'd5,2'd0, 3'd5,3'd1,2'd1, 3'd6,3'd0, 1'b0,1'b1,1'b1, 3'b000,4'd12}, // R3 R9
    '{3'd1,3'd2,2'd0, 3'd2,3'd3,2'd0, 3'd1,3'd1, 1'b0,1'b0,1'b0, 3'b111,4'd9},  // R4
    '{3'd0,3'd0,2'd0, 3'd2,3'd3,2'd0, 3'd0,3'd1, 1'b1,1'b0,1'b1, 3'b000,4'd3},  // R7 R8 R4
    '{3'd5,3'd4,2'd3, 3'd0,3'd5,2'd0, 3'd6,3'd2, 1'b1,1'b1,1'b1, 3'b000,4'd12}, // R3 R8
    '{3'd7,3'd3,2'd0, 3'd3,3'd0,2'd2, 3'd2,3'd4, 1'b0,1'b1,1'b1, 3'b001,4'd5},  // R4 R8
    '{3'd0,3'd6,2'd2, 3'd1,3'd7,2'd3, 3'd4,3'd1, 1'b0,1'b1,1'b1, 3'b000,4'd10}  // R6 R3
  };

  task automatic check(input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Expected absolute specifier {frame, reg}.
  function automatic logic [FW+RW-1:0] tb_abs(input logic [2:0] b,
                                              input logic [RW-1:0] r);
    logic [FW-1:0] fr;
    if (b == 3'd4) return trap_src1;
    if (b == 3'd5) return trap_src2;
    if (b == 3'd6) return trap_dst;
    if (b == 3'd1)      fr = chd_frame;
    else if (b == 3'd2) fr = par_frame;
    else if (b == 3'd3) fr = 4'd7;
    else                fr = cur_frame;
    return {fr, r};
  endfunction

  function automatic logic tb_bad(input logic [2:0] b);
    return (b == 3'd1 && !chd_ok) || (b == 3'd2 && !par_ok) || (b == 3'd7);
  endfunction

  function automatic logic [WW-1:0] tb_opnd(input logic [FW+RW-1:0] a,
                                            input logic [1:0] fld,
                                            input logic use_imm,
                                            input logic [DW-1:0] iv);
    logic [WW-1:0] w;
    if (use_imm) return {2'b00, FIX, iv};
    w = (a[RW-1:0] == '0) ? {2'b00, FIX, 16'h0000} : rf_model(a[FW+RW-1:RW], a[RW-1:0]);
    if (fld == 2'd1) return {2'b00, FIX, w[15:0]};
    if (fld == 2'd2) return {2'b00, FIX, 14'h0, w[21:20]};
    if (fld == 2'd3) return {2'b00, FIX, 12'h0, w[19:16]};
    return w;
  endfunction

  task automatic apply(input vec_t v, input logic [DW-1:0] iv);
    spec_a_base = v.ab; spec_a_reg = v.ar; spec_a_fld = v.af;
    spec_b_base = v.bb; spec_b_reg = v.br; spec_b_fld = v.bf;
    spec_d_base = v.db; spec_d_reg = v.dr;
    imm_en = v.ie; par_ok = v.pok; chd_ok = v.cok; imm = iv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [WW-1:0] ea, eb, held_a;
    logic [FW+RW-1:0] xa, xb, xd;
    logic [2:0] xbad;
    rst_n = 1'b0; req_valid = 1'b0;
    cur_frame = 4'd3; par_frame = 4'd5; chd_frame = 4'd9;
    trap_src1 = {4'd10, 3'd2}; trap_src2 = {4'd11, 3'd0}; trap_dst = {4'd12, 3'd6};
    apply(VECS[0], 16'h0);
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", 32'(out_valid), 0);
    check("R11 opnd_a", 32'(opnd_a), 0);
    check("R11 opnd_b/dst/bad", 32'({opnd_b, dst_frame, dst_reg, spec_bad}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      apply(VECS[i], 16'h1000 + 16'(i) * 16'h0111);
      req_valid = 1'b1;
      xa = tb_abs(VECS[i].ab, VECS[i].ar);
      xb = tb_abs(VECS[i].bb, VECS[i].br);
      xd = tb_abs(VECS[i].db, VECS[i].dr);
      xbad = {tb_bad(VECS[i].db), tb_bad(VECS[i].bb) & ~VECS[i].ie, tb_bad(VECS[i].ab)};
      ea = tb_opnd(xa, VECS[i].af, 1'b0, imm);
      eb = tb_opnd(xb, VECS[i].bf, VECS[i].ie, imm);
      #1;
      // R12 with R1/R2/R3: read addresses in the request cycle
      check($sformatf("R12 rf_a addr v%0d", i), 32'({rf_a_frame, rf_a_reg}), 32'(xa));
      if (!VECS[i].ie)
        check($sformatf("R12 rf_b addr v%0d", i), 32'({rf_b_frame, rf_b_reg}), 32'(xb));
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R10 out_valid v%0d", i), 32'(out_valid), 1);
      check($sformatf("R5/R6/R8 opnd_a v%0d", i), 32'(opnd_a), 32'(ea));
      check($sformatf("R7/R6 opnd_b v%0d", i), 32'(opnd_b), 32'(eb));
      check($sformatf("R9 dst v%0d", i), 32'({dst_frame, dst_reg}), 32'(xd));
      check($sformatf("R9 dst table v%0d", i), 32'(dst_frame), 32'(VECS[i].xdf));
      check($sformatf("R4 spec_bad v%0d", i), 32'(spec_bad), 32'(xbad));
      check($sformatf("R4 spec_bad table v%0d", i), 32'(spec_bad), 32'(VECS[i].xbad));
    end

    // R10: outputs hold while no request, even with inputs changing
    apply(VECS[1], 16'h0);
    req_valid = 1'b1;
    held_a = tb_opnd(tb_abs(3'd1, 3'd4), 2'd1, 1'b0, 16'h0);
    @(negedge clk);
    req_valid = 1'b0;
    apply(VECS[4], 16'hBEEF);
    cur_frame = 4'd14;
    @(negedge clk);
    check("R10 out_valid drops", 32'(out_valid), 0);
    check("R10 opnd_a holds", 32'(opnd_a), 32'(held_a));
    check("R10 spec_bad holds", 32'(spec_bad), 0);
    check("R10 dst holds", 32'({dst_frame, dst_reg}), 32'({4'd9, 3'd6}));

    // R11: asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    check("R11 mid-run clear", 32'({out_valid, opnd_a}), 0);
    check("R11 mid-run dst", 32'({dst_frame, dst_reg}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule